// File: doc/BRIEF.md
# I2S Master Clock and Frame Generator

This block is the timing source for an I2S master. From a single fast input clock it produces the serial bit clock, the left/right word-select line and an optional master clock for an external converter. It also produces two one-cycle strobes for the data path: one at the start of every bit slot and one at the first bit of every channel. Serial data shifting is not part of the block.

The divide ratio is N = 2·DIV + ODD. DIV is an 8-bit integer and ODD is a single bit, so odd ratios are possible. For an odd N, the high phase of a divided clock is one input cycle longer than its low phase.

When the master clock is enabled, it runs at fclk/N, which is 256·Fs. The bit clock is then the master clock divided by 4 for 32-bit channels or by 8 for 16-bit channels, so the sample rate does not depend on the channel length. When the master clock is off, the bit clock runs at fclk/N, so Fs is fclk/(32N) for 16-bit channels and fclk/(64N) for 32-bit channels.

The configuration is captured when the generator starts. The generator starts in the first cycle in which the enable is high and DIV is at least 2.

Top module: `i2s_clkgen`

## Requirements
- R1: While en is low, and from the second cycle after en falls, mck_o, ws_o, bit_stb and ch_stb are 0 and bck_o equals ck_pol. After reset the same idle state holds.
- R2: A DIV value of 0 or 1 never starts the generator. With en held high, the outputs stay idle and no bit_stb appears.
- R3: With the master clock off, a bit-clock period lasts N = 2·DIV+ODD input cycles. With ck_pol=0 it is low for DIV cycles and then high for DIV+ODD cycles.
- R4: ck_pol=1 inverts bck_o: it idles high, is high in the first phase of each bit slot and is low for DIV+ODD cycles.
- R5: With the master clock on, mck_o has period N, high for DIV+ODD and low for DIV cycles. bck_o has period 4N (32-bit channels) or 8N (16-bit), each half lasting an equal number of master-clock periods.
- R6: With mck_en=0 captured at start, mck_o stays 0 the whole time the generator runs.
- R7: A frame holds 2·CH bit slots, where CH is 16 (ch_long=0) or 32 (ch_long=1). Numbering the slots from 0 at the left channel's first bit, ws_o is 1 in slots CH-1 to 2·CH-2 and 0 in the others. ws_o therefore changes only at the start of a slot, one slot before each channel's first bit.
- R8: bit_stb is a one-cycle pulse in the first cycle of every bit slot, which is the cycle in which bck_o enters its first phase.
- R9: ch_stb pulses together with bit_stb at slots 0 and CH only, giving two per frame.
- R10: A frame lasts 32N input cycles (16-bit, master clock off), 64N (32-bit, master clock off) or 256N (master clock on). For example, DIV=16/ODD=0 gives 1024 cycles, DIV=19/ODD=0 at 16-bit equals DIV=9/ODD=1 at 32-bit, and DIV=3/ODD=0 with the master clock on gives 1536 cycles.
- R11: DIV, ODD, mck_en, ck_pol and ch_long are captured when the generator starts. Changing them while it runs has no effect on the outputs.
- R12: On every start, the second cycle after en is seen high shows bit_stb=1, ch_stb=1 and ws_o=0, so each start begins on the left channel's first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run request |
| div_val | input | 8 | Integer part DIV of the divider |
| div_odd | input | 1 | Odd bit of the divider |
| mck_en | input | 1 | Drive the master clock and use the master-clock divider chain |
| ck_pol | input | 1 | Idle level of the bit clock |
| ch_long | input | 1 | 1: 32-bit channels, 0: 16-bit channels |
| mck_o | output | 1 | Master clock (0 when disabled or not enabled) |
| bck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select, 0 left / 1 right |
| bit_stb | output | 1 | Start-of-bit-slot strobe |
| ch_stb | output | 1 | First-bit-of-channel strobe |

## Verification
The bench drives odd divide ratios in both chains, because a design that split N as two equal halves would give the wrong high time or the wrong period there. It compares frame lengths across the two channel lengths and across the two master-clock settings. A design that applied the master-clock divider in the wrong branch, or that halved the ratio for the wrong channel length, would show a frame off by a factor of two. It also walks the word-select pattern slot by slot to catch a word select that changes on the channel's first bit rather than one bit early. It also changes the configuration in mid-run and restarts, which exposes a design that reads its settings live or that resumes mid-frame.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;
  localparam int DEF_DIV_W   = 8;
  localparam int SHORT_CH    = 16;
  localparam int LONG_CH     = 32;
  localparam int SHORT_MDIV  = 8;  // mck periods per bit clock, 16-bit channels
  localparam int LONG_MDIV   = 4;  // mck periods per bit clock, 32-bit channels

  typedef struct packed {
    logic bck;
    logic ws;
    logic mck;
    logic bit_stb;
    logic ch_stb;
  } i2s_pins_t;
endpackage

// File: rtl/i2s_start_ctl.sv
module i2s_start_ctl #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             div_odd,
  input  logic             mck_en,
  input  logic             ck_pol,
  input  logic             ch_long,
  output logic             run,
  output logic [DIV_W-1:0] div_q,
  output logic             odd_q,
  output logic             mck_q,
  output logic             pol_q,
  output logic             long_q
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic cfg_ok;
  assign cfg_ok = (div_val >= MIN_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      div_q  <= '0;
      odd_q  <= 1'b0;
      mck_q  <= 1'b0;
      pol_q  <= 1'b0;
      long_q <= 1'b0;
    end else if (!en) begin
      run <= 1'b0;
    end else if (!run && cfg_ok) begin
      run    <= 1'b1;
      div_q  <= div_val;
      odd_q  <= div_odd;
      mck_q  <= mck_en;
      pol_q  <= ck_pol;
      long_q <= ch_long;
    end
  end
endmodule

// File: rtl/i2s_prescaler.sv
module i2s_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_q,
  input  logic             odd_q,
  output logic             first,
  output logic             wrap,
  output logic             hi
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] cnt;

  assign ratio = {div_q, 1'b0} + CNT_W'(odd_q);
  assign first = (cnt == '0);
  assign wrap  = (cnt == ratio - CNT_W'(1));
  // low phase DIV cycles, high phase DIV+ODD cycles
  assign hi    = (cnt >= {1'b0, div_q});

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (wrap)   cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/i2s_bit_divider.sv
module i2s_bit_divider
  import i2s_clkgen_pkg::*;
#(
  parameter bit MCK_SUPPORT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic mck_q,
  input  logic long_q,
  input  logic pre_first,
  input  logic pre_wrap,
  input  logic pre_hi,
  output logic bit_hi,
  output logic bit_first,
  output logic bit_wrap
);
  localparam int MCNT_W = $clog2(SHORT_MDIV);

  generate
    if (MCK_SUPPORT) begin : g_mck
      logic [MCNT_W-1:0] mcnt;
      logic [MCNT_W-1:0] mlast;
      logic [MCNT_W-1:0] mhalf;

      assign mlast = long_q ? MCNT_W'(LONG_MDIV - 1) : MCNT_W'(SHORT_MDIV - 1);
      assign mhalf = long_q ? MCNT_W'(LONG_MDIV / 2) : MCNT_W'(SHORT_MDIV / 2);

      always_ff @(posedge clk) begin
        if (rst || !run || !mck_q)  mcnt <= '0;
        else if (pre_wrap) begin
          if (mcnt == mlast) mcnt <= '0;
          else               mcnt <= mcnt + MCNT_W'(1);
        end
      end

      assign bit_hi    = mck_q ? (mcnt >= mhalf) : pre_hi;
      assign bit_first = pre_first && (!mck_q || mcnt == '0);
      assign bit_wrap  = pre_wrap  && (!mck_q || mcnt == mlast);
    end else begin : g_direct
      assign bit_hi    = pre_hi;
      assign bit_first = pre_first;
      assign bit_wrap  = pre_wrap;
    end
  endgenerate
endmodule

// File: rtl/i2s_slot_seq.sv
module i2s_slot_seq
  import i2s_clkgen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic long_q,
  input  logic bit_first,
  input  logic bit_wrap,
  output logic ws_val,
  output logic chan_start
);
  localparam int SLOT_W = $clog2(2 * LONG_CH);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] ch_len;
  logic [SLOT_W-1:0] slot_last;

  assign ch_len    = long_q ? SLOT_W'(LONG_CH) : SLOT_W'(SHORT_CH);
  assign slot_last = long_q ? SLOT_W'(2 * LONG_CH - 1) : SLOT_W'(2 * SHORT_CH - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) slot <= '0;
    else if (bit_wrap) begin
      if (slot == slot_last) slot <= '0;
      else                   slot <= slot + SLOT_W'(1);
    end
  end

  // right-channel select one slot ahead of each channel's first bit
  assign ws_val     = (slot >= ch_len - SLOT_W'(1)) && (slot < slot_last);
  assign chan_start = bit_first && (slot == '0 || slot == ch_len);
endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clkgen_pkg::*;
#(
  parameter int DIV_W       = DEF_DIV_W,
  parameter bit MCK_SUPPORT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             div_odd,
  input  logic             mck_en,
  input  logic             ck_pol,
  input  logic             ch_long,
  output logic             mck_o,
  output logic             bck_o,
  output logic             ws_o,
  output logic             bit_stb,
  output logic             ch_stb
);
  logic             run;
  logic [DIV_W-1:0] div_q;
  logic             odd_q, mck_q, pol_q, long_q;
  logic             pre_first, pre_wrap, pre_hi;
  logic             bit_hi, bit_first, bit_wrap;
  logic             ws_val, chan_start;
  i2s_pins_t        pins_n, pins_q;

  i2s_start_ctl #(.DIV_W(DIV_W)) u_start (
    .clk(clk), .rst(rst), .en(en), .div_val(div_val), .div_odd(div_odd),
    .mck_en(mck_en), .ck_pol(ck_pol), .ch_long(ch_long),
    .run(run), .div_q(div_q), .odd_q(odd_q), .mck_q(mck_q),
    .pol_q(pol_q), .long_q(long_q)
  );

  i2s_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .div_q(div_q), .odd_q(odd_q),
    .first(pre_first), .wrap(pre_wrap), .hi(pre_hi)
  );

  i2s_bit_divider #(.MCK_SUPPORT(MCK_SUPPORT)) u_bdiv (
    .clk(clk), .rst(rst), .run(run), .mck_q(mck_q), .long_q(long_q),
    .pre_first(pre_first), .pre_wrap(pre_wrap), .pre_hi(pre_hi),
    .bit_hi(bit_hi), .bit_first(bit_first), .bit_wrap(bit_wrap)
  );

  i2s_slot_seq u_slot (
    .clk(clk), .rst(rst), .run(run), .long_q(long_q),
    .bit_first(bit_first), .bit_wrap(bit_wrap),
    .ws_val(ws_val), .chan_start(chan_start)
  );

  always_comb begin
    pins_n.bck     = run ? (bit_hi ^ pol_q) : ck_pol;
    pins_n.mck     = run && mck_q && pre_hi && MCK_SUPPORT;
    pins_n.ws      = run && ws_val;
    pins_n.bit_stb = run && bit_first;
    pins_n.ch_stb  = run && chan_start;
  end

  always_ff @(posedge clk) begin
    if (rst) pins_q <= '0;
    else     pins_q <= pins_n;
  end

  assign bck_o   = pins_q.bck;
  assign mck_o   = pins_q.mck;
  assign ws_o    = pins_q.ws;
  assign bit_stb = pins_q.bit_stb;
  assign ch_stb  = pins_q.ch_stb;
endmodule

// File: rtl/i2s_clkgen_chk.sv
module i2s_clkgen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [DIV_W-1:0] div_val,
  input logic             mck_o,
  input logic             ws_o,
  input logic             bit_stb,
  input logic             ch_stb,
  input logic             run,
  input logic             mck_q,
  input logic [DIV_W-1:0] div_q
);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!en, 2) |-> (!mck_o && !ws_o && !bit_stb && !ch_stb));

  p_bad_div_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && en && div_val < DIV_W'(2)) |=> !run);

  p_mck_gated_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!mck_q) |-> !mck_o);

  p_ws_on_slot_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && ws_o != $past(ws_o)) |-> bit_stb);

  p_stb_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

  p_ch_in_bit_r9: assert property (@(posedge clk) disable iff (rst)
    ch_stb |-> bit_stb);

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(div_q));
endmodule

bind i2s_clkgen i2s_clkgen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .div_val(div_val), .mck_o(mck_o),
  .ws_o(ws_o), .bit_stb(bit_stb), .ch_stb(ch_stb), .run(run),
  .mck_q(mck_q), .div_q(div_q)
);

// File: tb/i2s_clkgen_test.sv
module i2s_clkgen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] div_val = 8'd3;
  logic       div_odd = 1'b0;
  logic       mck_en = 1'b0;
  logic       ck_pol = 1'b0;
  logic       ch_long = 1'b0;
  logic       mck_o, bck_o, ws_o, bit_stb, ch_stb;
  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  i2s_clkgen uut (
    .clk(clk), .rst(rst), .en(en), .div_val(div_val), .div_odd(div_odd),
    .mck_en(mck_en), .ck_pol(ck_pol), .ch_long(ch_long),
    .mck_o(mck_o), .bck_o(bck_o), .ws_o(ws_o), .bit_stb(bit_stb), .ch_stb(ch_stb)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic start(input int d, input bit o, input bit m, input bit p, input bit l);
    @(negedge clk);
    div_val = d[7:0]; div_odd = o; mck_en = m; ck_pol = p; ch_long = l; en = 1'b1;
  endtask

  task automatic stop();
    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // bit-slot period and cycles spent in the second (non-idle-level) phase
  task automatic measure_bck(input bit pol, output int per, output int act);
    int guard = 0;
    per = -1; act = -1;
    do begin @(negedge clk); guard++; end while (!bit_stb && guard < 5000);
    if (!bit_stb) return;
    per = 0; act = 0;
    do begin
      per++; act += int'(bck_o ^ pol);
      @(negedge clk);
    end while (!bit_stb && per < 5000);
  endtask

  task automatic measure_mck(output int per, output int hi);
    int guard = 0;
    logic prev;
    per = -1; hi = -1;
    @(negedge clk); prev = mck_o;
    do begin @(negedge clk); guard++; if (!(mck_o && !prev)) prev = mck_o; end
      while (!(mck_o && !prev) && guard < 5000);
    if (!mck_o || prev) return;
    per = 0; hi = 0; prev = 1'b1;
    do begin
      per++; hi += int'(mck_o); prev = mck_o;
      @(negedge clk);
    end while (!(mck_o && !prev) && per < 5000);
  endtask

  // one frame starting at a left-channel first bit
  task automatic measure_frame(input int ch, output int flen, output int nbits,
                               output int nch, output int ws_err, output int mck_hi);
    int guard = 0;
    int k = -1;
    flen = -1; nbits = 0; nch = 0; ws_err = 0; mck_hi = 0;
    do begin @(negedge clk); guard++; end while (!(ch_stb && !ws_o) && guard < 20000);
    if (!(ch_stb && !ws_o)) return;
    flen = 0;
    do begin
      if (bit_stb) begin
        k++; nbits++;
        if (int'(ws_o) != int'(k >= ch - 1 && k <= 2 * ch - 2)) ws_err++;
      end
      if (ch_stb) nch++;
      mck_hi += int'(mck_o);
      flen++;
      @(negedge clk);
    end while (!(ch_stb && !ws_o) && flen < 20000);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "idle bck", int'(bck_o), 0);
    check("R1", "idle ws/mck/stb", int'({ws_o, mck_o, bit_stb, ch_stb}), 0);
  endtask

  task automatic t_odd_no_mck();
    int per, act, fl, nb, nc, we, mh;
    start(3, 1, 0, 0, 0);
    measure_bck(1'b0, per, act);
    check("R3", "bck period N=7", per, 7);
    check("R3", "bck high cycles", act, 4);
    check("R8", "bck low at bit_stb", act, per - 3);
    measure_frame(16, fl, nb, nc, we, mh);
    check("R10", "frame 32N", fl, 224);
    check("R7", "slots per frame", nb, 32);
    check("R7", "ws pattern errors 16-bit", we, 0);
    check("R9", "ch_stb per frame", nc, 2);
    stop();
  endtask

  task automatic t_worked_no_mck();
    int fl, nb, nc, we, mh;
    start(16, 0, 0, 0, 0);
    measure_frame(16, fl, nb, nc, we, mh);
    check("R10", "DIV16 16-bit frame", fl, 1024);
    check("R6", "mck idle with mck off", mh, 0);
    stop();
    start(19, 0, 0, 0, 0);
    measure_frame(16, fl, nb, nc, we, mh);
    check("R10", "DIV19 16-bit frame", fl, 1216);
    stop();
    start(9, 1, 0, 0, 1);
    measure_frame(32, fl, nb, nc, we, mh);
    check("R10", "DIV9 ODD 32-bit frame", fl, 1216);
    check("R7", "ws pattern errors 32-bit", we, 0);
    stop();
  endtask

  task automatic t_mck_on();
    int per, act, fl, nb, nc, we, mh;
    start(3, 0, 1, 0, 1);
    measure_mck(per, act);
    check("R5", "mck period", per, 6);
    check("R5", "mck high", act, 3);
    measure_bck(1'b0, per, act);
    check("R5", "bck period 4N", per, 24);
    check("R5", "bck high 2N", act, 12);
    measure_frame(32, fl, nb, nc, we, mh);
    check("R10", "mck-on 32-bit frame", fl, 1536);
    check("R7", "mck-on ws errors", we, 0);
    stop();
    start(3, 0, 1, 0, 0);
    measure_bck(1'b0, per, act);
    check("R5", "bck period 8N", per, 48);
    measure_frame(16, fl, nb, nc, we, mh);
    check("R10", "mck-on 16-bit frame", fl, 1536);
    check("R7", "mck-on 16-bit slots", nb, 32);
    stop();
    start(2, 1, 1, 0, 1);
    measure_mck(per, act);
    check("R5", "odd mck period", per, 5);
    check("R5", "odd mck high", act, 3);
    stop();
  endtask

  task automatic t_polarity();
    int per, act;
    @(negedge clk); ck_pol = 1'b1;
    repeat (2) @(negedge clk);
    check("R4", "idle high", int'(bck_o), 1);
    start(3, 1, 0, 1, 0);
    measure_bck(1'b1, per, act);
    check("R4", "inverted period", per, 7);
    check("R4", "low cycles inverted", act, 4);
    stop();
    ck_pol = 1'b0;
  endtask

  task automatic t_invalid();
    int seen = 0;
    start(1, 1, 1, 0, 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      seen += int'(bit_stb || mck_o || bck_o);
    end
    check("R2", "DIV=1 stays idle", seen, 0);
    stop();
    seen = 0;
    start(0, 0, 0, 0, 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      seen += int'(bit_stb || bck_o || ws_o);
    end
    check("R2", "DIV=0 stays idle", seen, 0);
    stop();
  endtask

  task automatic t_live_change_and_restart();
    int per, act, fl, nb, nc, we, mh;
    start(3, 1, 0, 0, 0);
    repeat (50) @(negedge clk);
    div_val = 8'd10; div_odd = 1'b0; mck_en = 1'b1; ch_long = 1'b1; ck_pol = 1'b1;
    measure_bck(1'b0, per, act);
    check("R11", "period unchanged", per, 7);
    measure_frame(16, fl, nb, nc, we, mh);
    check("R11", "frame unchanged", fl, 224);
    check("R11", "mck still off", mh, 0);
    @(negedge clk); en = 1'b0;
    div_val = 8'd3; div_odd = 1'b1; mck_en = 1'b0; ch_long = 1'b0; ck_pol = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "idle after disable", int'({bck_o, ws_o, mck_o, bit_stb, ch_stb}), 0);
    en = 1'b1;
    repeat (2) @(negedge clk);
    check("R12", "restart bit/ch strobe, ws low", int'({bit_stb, ch_stb, ws_o}), 3'b110);
    stop();
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_odd_no_mck();
    t_worked_no_mck();
    t_mck_on();
    t_polarity();
    t_invalid();
    t_live_change_and_restart();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule